// File: doc/BRIEF.md
# Rotate, Shift and Bit-Test Unit

This unit computes the bit-oriented operations of an 8-bit processor datapath. It covers four families of operation:

- the fast rotates that act on the accumulator alone;
- the eight prefixed rotates and shifts, including the shift left that inserts a 1;
- the two nibble rotates that move 4-bit halves between the accumulator and a memory byte;
- bit test, bit set and bit clear, selected by a 3-bit index.

Memory access and instruction decode stay outside. The sequencer presents the operand byte, the accumulator, the carry, the current flag byte, an operation class, a 3-bit sub-operation and a bit index. The result byte, a second byte (the rewritten memory byte for the nibble rotates) and the new flag byte come back one clock later.

The operation logic itself is combinational. A single output register stage, qualified by a valid strobe, gives the sequencer a clean timing boundary. A small control module turns the class and sub-operation into a struct of strobes. The datapath module uses that struct to steer one shared shifter, the nibble swap and the bit-mask logic.

Top module: `bitop_unit`

## Requirements
- R1: Outputs are registered. A request with `inValid` high at a rising edge appears on `resByte`, `auxByte` and `flagsOut` with `outValid` high after that same edge. `outValid` is low in any cycle whose request had `inValid` low. Reset (active-low `rstN`) clears all outputs to 0.
- R2: Class 1 (prefixed shift) acts on `operand`. The sub-op values are:
  - 000: rotate left circular
  - 001: rotate right circular
  - 010: rotate left through `carryIn`
  - 011: rotate right through `carryIn`
  - 100: shift left with 0 in
  - 101: shift right arithmetic (bit 7 kept)
  - 110: shift left with 1 in
  - 111: shift right with 0 in

  The bit shifted out becomes C. `auxByte` is 0.
- R3: The flag byte is laid out as S=bit 7, Z=6, F5=5, H=4, F3=3, P/V=2, N=1, C=0. For class 1:
  - S, F5 and F3 are result bits 7, 5 and 3.
  - Z is set when the result is zero.
  - P/V is 1 when the result has even parity.
  - H and N are 0.
- R4: Class 0 (accumulator rotate) acts on `accIn`, with sub-op bits [1:0] selecting the same four rotates as R2 codes 000 to 011; sub-op bit 2 is ignored. C takes the bit shifted out, F5 and F3 come from the result, H and N are 0, and S, Z and P/V are copied from `flagsIn`.
- R5: Class 2 (nibble rotate) with sub-op bit 0 = 0 gives new accumulator {A[7:4], M[7:4]} on `resByte` and new memory {M[3:0], A[3:0]} on `auxByte`. With bit 0 = 1 it gives accumulator {A[7:4], M[3:0]} and memory {A[3:0], M[7:4]}. Here M is `operand` and A is `accIn`.
- R6: For class 2:
  - S, Z, F5, F3 and P/V are set from the new accumulator as in R3.
  - H and N are 0.
  - C equals `carryIn`.
- R7: Class 3 (bit test) of `operand` bit `bitIdx`:
  - Z is the inverse of the tested bit, and P/V equals Z.
  - H is 1, N is 0 and C equals `carryIn`.
  - `resByte` equals `operand` and `auxByte` is 0.
- R8: For class 3, S is 1 only when the index is 7 and the tested bit is 1. F5 and F3 follow the same rule with indices 5 and 3.
- R9: Class 4 sets bit `bitIdx` of `operand` and class 5 clears it, leaving other bits unchanged. `flagsOut` equals `flagsIn` and `auxByte` is 0.
- R10: Class codes 6 and 7 pass `operand` to `resByte`, give `auxByte` 0 and copy `flagsIn` to `flagsOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opClass | input | 3 | Operation class |
| subOp | input | 3 | Sub-operation selector |
| bitIdx | input | 3 | Bit index for test, set and clear |
| operand | input | 8 | Operand or memory byte |
| accIn | input | 8 | Accumulator value |
| carryIn | input | 1 | Incoming carry |
| flagsIn | input | 8 | Incoming flag byte |
| outValid | output | 1 | Result valid |
| resByte | output | 8 | Main result byte |
| auxByte | output | 8 | Rewritten memory byte for nibble rotates, else 0 |
| flagsOut | output | 8 | New flag byte |

## Verification
The bench sweeps every class, sub-op and bit index with operands 00, FF, 80, 01, A5, 5A and 3C, each with the carry at both values.

Each operand separates a different kind of error:
- 80 and 01 separate fill-bit and carry-out mistakes on the two edges of the byte.
- 00 and FF test the zero flag and the arithmetic shift's sign fill.
- A5, 5A and 3C have distinct nibbles, so a swapped half in the nibble rotates shows.
- The alternating patterns, tested at every index, make a wrong bit position in test, set and clear visible, and show whether S, F5 and F3 leak at the wrong index.

Varying the incoming flag byte shows which flags are preserved and which are recomputed.

// File: rtl/bitop_pkg.sv
`timescale 1ns/1ps
package bitop_pkg;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int NIB_W  = DATA_W / 2;
  localparam int OPC_W  = 3;
  localparam int SUB_W  = 3;

  // flag byte positions
  localparam int F_S  = 7;
  localparam int F_Z  = 6;
  localparam int F_5  = 5;
  localparam int F_H  = 4;
  localparam int F_3  = 3;
  localparam int F_PV = 2;
  localparam int F_N  = 1;
  localparam int F_C  = 0;

  typedef enum logic [OPC_W-1:0] {
    OPC_ACCROT = 3'd0,
    OPC_SHIFT  = 3'd1,
    OPC_NIBBLE = 3'd2,
    OPC_BIT    = 3'd3,
    OPC_SET    = 3'd4,
    OPC_CLR    = 3'd5
  } opc_e;

  typedef struct packed {
    logic accRot;
    logic shift;
    logic nibble;
    logic bitTest;
    logic bitSet;
    logic bitClr;
    logic dirRight;
    logic viaCarry;
    logic circular;
    logic fillOne;
    logic arith;
    logic nibRight;
  } ctl_t;
endpackage

// File: rtl/bitop_ctrl.sv
`timescale 1ns/1ps
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic [OPC_W-1:0] opClass,
  input  logic [SUB_W-1:0] subOp,
  output ctl_t             ctl
);
  always_comb begin
    ctl = '0;
    unique case (opClass)
      OPC_ACCROT: begin
        ctl.accRot   = 1'b1;
        ctl.dirRight = subOp[0];
        ctl.viaCarry = subOp[1];
        ctl.circular = ~subOp[1];
      end
      OPC_SHIFT: begin
        ctl.shift    = 1'b1;
        ctl.dirRight = subOp[0];
        ctl.circular = (subOp[2:1] == 2'b00);
        ctl.viaCarry = (subOp[2:1] == 2'b01);
        ctl.fillOne  = (subOp == 3'b110);
        ctl.arith    = (subOp == 3'b101);
      end
      OPC_NIBBLE: begin
        ctl.nibble   = 1'b1;
        ctl.nibRight = subOp[0];
      end
      OPC_BIT: ctl.bitTest = 1'b1;
      OPC_SET: ctl.bitSet  = 1'b1;
      OPC_CLR: ctl.bitClr  = 1'b1;
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/bitop_dp.sv
`timescale 1ns/1ps
module bitop_dp
  import bitop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  ctl_t              ctl,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resByte,
  output logic [DATA_W-1:0] auxByte,
  output logic [DATA_W-1:0] flagsOut
);
  logic [DATA_W-1:0] srcByte, shByte, bitMask, nibAcc, nibMem;
  logic [DATA_W-1:0] nextRes, nextAux, nextFlags;
  logic              inBit, shCarry, testedBit;

  // one-hot bit mask from the index
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign bitMask[g] = (bitIdx == IDX_W'(g));
  end

  // shared shifter
  assign srcByte = ctl.accRot ? accIn : operand;

  always_comb begin
    if (ctl.circular)      inBit = ctl.dirRight ? srcByte[0] : srcByte[DATA_W-1];
    else if (ctl.viaCarry) inBit = carryIn;
    else if (ctl.dirRight) inBit = ctl.arith & srcByte[DATA_W-1];
    else                   inBit = ctl.fillOne;
  end

  assign shByte  = ctl.dirRight ? {inBit, srcByte[DATA_W-1:1]}
                                : {srcByte[DATA_W-2:0], inBit};
  assign shCarry = ctl.dirRight ? srcByte[0] : srcByte[DATA_W-1];

  // nibble exchange between accumulator and memory byte
  always_comb begin
    if (ctl.nibRight) begin
      nibAcc = {accIn[DATA_W-1:NIB_W], operand[NIB_W-1:0]};
      nibMem = {accIn[NIB_W-1:0], operand[DATA_W-1:NIB_W]};
    end else begin
      nibAcc = {accIn[DATA_W-1:NIB_W], operand[DATA_W-1:NIB_W]};
      nibMem = {operand[NIB_W-1:0], accIn[NIB_W-1:0]};
    end
  end

  assign testedBit = |(operand & bitMask);

  function automatic logic [DATA_W-1:0] resultFlags(input logic [DATA_W-1:0] v,
                                                   input logic c);
    logic [DATA_W-1:0] f;
    f       = '0;
    f[F_S]  = v[DATA_W-1];
    f[F_Z]  = (v == '0);
    f[F_5]  = v[5];
    f[F_3]  = v[3];
    f[F_PV] = ~^v;
    f[F_C]  = c;
    return f;
  endfunction

  always_comb begin
    nextRes   = operand;
    nextAux   = '0;
    nextFlags = flagsIn;
    if (ctl.shift) begin
      nextRes   = shByte;
      nextFlags = resultFlags(shByte, shCarry);
    end else if (ctl.accRot) begin
      nextRes         = shByte;
      nextFlags[F_5]  = shByte[5];
      nextFlags[F_3]  = shByte[3];
      nextFlags[F_H]  = 1'b0;
      nextFlags[F_N]  = 1'b0;
      nextFlags[F_C]  = shCarry;
    end else if (ctl.nibble) begin
      nextRes   = nibAcc;
      nextAux   = nibMem;
      nextFlags = resultFlags(nibAcc, carryIn);
    end else if (ctl.bitTest) begin
      nextFlags       = '0;
      nextFlags[F_Z]  = ~testedBit;
      nextFlags[F_PV] = ~testedBit;
      nextFlags[F_H]  = 1'b1;
      nextFlags[F_S]  = testedBit & bitMask[7];
      nextFlags[F_5]  = testedBit & bitMask[5];
      nextFlags[F_3]  = testedBit & bitMask[3];
      nextFlags[F_C]  = carryIn;
    end else if (ctl.bitSet) begin
      nextRes = operand | bitMask;
    end else if (ctl.bitClr) begin
      nextRes = operand & ~bitMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resByte  <= '0;
      auxByte  <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resByte  <= nextRes;
        auxByte  <= nextAux;
        flagsOut <= nextFlags;
      end
    end
  end
endmodule

// File: rtl/bitop_unit.sv
`timescale 1ns/1ps
module bitop_unit
  import bitop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opClass,
  input  logic [SUB_W-1:0]  subOp,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] accIn,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] resByte,
  output logic [DATA_W-1:0] auxByte,
  output logic [DATA_W-1:0] flagsOut
);
  ctl_t ctl;

  bitop_ctrl u_ctrl (
    .opClass (opClass),
    .subOp   (subOp),
    .ctl     (ctl)
  );

  bitop_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .bitIdx   (bitIdx),
    .operand  (operand),
    .accIn    (accIn),
    .carryIn  (carryIn),
    .flagsIn  (flagsIn),
    .outValid (outValid),
    .resByte  (resByte),
    .auxByte  (auxByte),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/bitop_chk.sv
`timescale 1ns/1ps
module bitop_chk
  import bitop_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OPC_W-1:0]  opClass,
  input logic [SUB_W-1:0]  subOp,
  input logic [IDX_W-1:0]  bitIdx,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] accIn,
  input logic              carryIn,
  input logic [DATA_W-1:0] flagsIn,
  input logic              outValid,
  input logic [DATA_W-1:0] resByte,
  input logic [DATA_W-1:0] auxByte,
  input logic [DATA_W-1:0] flagsOut
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_shift_flags_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) == OPC_SHIFT) |->
      (!flagsOut[F_H] && !flagsOut[F_N] && flagsOut[F_PV] == ~^resByte));

  p_accrot_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) == OPC_ACCROT) |->
      (flagsOut[F_S] == $past(flagsIn[F_S]) && flagsOut[F_Z] == $past(flagsIn[F_Z])
       && flagsOut[F_PV] == $past(flagsIn[F_PV])));

  p_nibble_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) == OPC_NIBBLE) |->
      (flagsOut[F_C] == $past(carryIn) && resByte[7:4] == $past(accIn[7:4])));

  p_bit_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) == OPC_BIT) |->
      (flagsOut[F_PV] == flagsOut[F_Z] && flagsOut[F_H] && !flagsOut[F_N]
       && flagsOut[F_C] == $past(carryIn)));

  p_bit_sign_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) == OPC_BIT && $past(bitIdx) != 3'd7) |->
      !flagsOut[F_S]);

  p_setclr_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(opClass) == OPC_SET || $past(opClass) == OPC_CLR)) |->
      (flagsOut == $past(flagsIn) && auxByte == '0));

  p_unused_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opClass) >= 3'd6) |->
      (resByte == $past(operand) && flagsOut == $past(flagsIn)));
endmodule

bind bitop_unit bitop_chk u_chk (.*);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [2:0] opClass = '0, subOp = '0, bitIdx = '0;
  logic [7:0] operand = '0, accIn = '0, flagsIn = '0;
  logic       carryIn = 1'b0;
  logic       outValid;
  logic [7:0] resByte, auxByte, flagsOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] cls;
    logic [2:0] idx;
    logic [7:0] res;
    logic [7:0] aux;
    logic [7:0] flg;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opClass(opClass),
    .subOp(subOp), .bitIdx(bitIdx), .operand(operand), .accIn(accIn),
    .carryIn(carryIn), .flagsIn(flagsIn), .outValid(outValid),
    .resByte(resByte), .auxByte(auxByte), .flagsOut(flagsOut)
  );

  function automatic item_t model(input logic [2:0] cls, input logic [2:0] sub,
                                  input logic [2:0] idx, input logic [7:0] o,
                                  input logic [7:0] a, input logic cin,
                                  input logic [7:0] fin);
    item_t it;
    logic [7:0] r;
    logic c, b;
    it.cls = cls; it.idx = idx; it.aux = 8'h00; it.res = o; it.flg = fin;
    case (cls)
      3'd0: begin
        case (sub[1:0])
          2'd0: begin r = {a[6:0], a[7]}; c = a[7]; end
          2'd1: begin r = {a[0], a[7:1]}; c = a[0]; end
          2'd2: begin r = {a[6:0], cin};  c = a[7]; end
          default: begin r = {cin, a[7:1]}; c = a[0]; end
        endcase
        it.res = r;
        it.flg = {fin[7], fin[6], r[5], 1'b0, r[3], fin[2], 1'b0, c};
      end
      3'd1: begin
        case (sub)
          3'd0: begin r = {o[6:0], o[7]}; c = o[7]; end
          3'd1: begin r = {o[0], o[7:1]}; c = o[0]; end
          3'd2: begin r = {o[6:0], cin};  c = o[7]; end
          3'd3: begin r = {cin, o[7:1]};  c = o[0]; end
          3'd4: begin r = {o[6:0], 1'b0}; c = o[7]; end
          3'd5: begin r = {o[7], o[7:1]}; c = o[0]; end
          3'd6: begin r = {o[6:0], 1'b1}; c = o[7]; end
          default: begin r = {1'b0, o[7:1]}; c = o[0]; end
        endcase
        it.res = r;
        it.flg = {r[7], r == 8'h00, r[5], 1'b0, r[3], ~^r, 1'b0, c};
      end
      3'd2: begin
        if (!sub[0]) begin
          it.aux = {o[3:0], a[3:0]}; r = {a[7:4], o[7:4]};
        end else begin
          it.aux = {a[3:0], o[7:4]}; r = {a[7:4], o[3:0]};
        end
        it.res = r;
        it.flg = {r[7], r == 8'h00, r[5], 1'b0, r[3], ~^r, 1'b0, cin};
      end
      3'd3: begin
        b = o[idx];
        it.flg = {(idx == 3'd7) && b, ~b, (idx == 3'd5) && b, 1'b1,
                  (idx == 3'd3) && b, ~b, 1'b0, cin};
      end
      3'd4: it.res = o | (8'h01 << idx);
      3'd5: it.res = o & ~(8'h01 << idx);
      default: ;
    endcase
    return it;
  endfunction

  task automatic send(input logic [2:0] cls, input logic [2:0] sub,
                      input logic [2:0] idx, input logic [7:0] o,
                      input logic [7:0] a, input logic cin, input logic [7:0] fin);
    @(negedge clk);
    opClass = cls; subOp = sub; bitIdx = idx; operand = o;
    accIn = a; carryIn = cin; flagsIn = fin; inValid = 1'b1;
    expQ.push_back(model(cls, sub, idx, o, a, cin, fin));
  endtask

  function automatic string resTag(input logic [2:0] cls);
    case (cls)
      3'd0: return "R4";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R7";
      3'd4, 3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string flgTag(input logic [2:0] cls, input logic [7:0] diff);
    case (cls)
      3'd0: return "R4";
      3'd1: return "R3";
      3'd2: return "R6";
      3'd3: return ((diff & 8'hA8) != 0) ? "R8" : "R7";
      3'd4, 3'd5: return "R9";
      default: return "R10";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished && outValid) begin
      item_t e;
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected outValid: actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        if (resByte !== e.res || auxByte !== e.aux) begin
          bad++;
          $display("FAIL %s class=%0d idx=%0d res/aux actual=%h/%h expected=%h/%h",
                   resTag(e.cls), e.cls, e.idx, resByte, auxByte, e.res, e.aux);
        end else if (flagsOut !== e.flg) begin
          bad++;
          $display("FAIL %s class=%0d idx=%0d flags actual=%b expected=%b",
                   flgTag(e.cls, flagsOut ^ e.flg), e.cls, e.idx, flagsOut, e.flg);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] pats[7];
    pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'h3C};
    repeat (3) @(negedge clk);
    // R1: reset state
    total++;
    if (outValid !== 1'b0 || resByte !== 8'h00 || auxByte !== 8'h00 || flagsOut !== 8'h00) begin
      bad++;
      $display("FAIL R1 reset state actual=%b/%h/%h/%h expected=0/00/00/00",
               outValid, resByte, auxByte, flagsOut);
    end
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle outValid actual=%b expected=0", outValid);
    end
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 8; s++)
        for (int i = 0; i < 8; i++)
          for (int p = 0; p < 7; p++)
            for (int ci = 0; ci < 2; ci++)
              send(3'(c), 3'(s), 3'(i), pats[p], pats[(p + 3) % 7], ci[0],
                   pats[(p + i + s) % 7] ^ 8'h24);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: no result without a request, and every request answered
    total++;
    if (outValid !== 1'b0 || expQ.size() != 0) begin
      bad++;
      $display("FAIL R1 drain actual=outValid %b pending %0d expected=0 pending 0",
               outValid, expQ.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule